// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept. When the receiver finishes a frame it presents the four identifier bytes in register layout and pulses a frame-complete strobe. The block compares those bytes against a 32-bit acceptance-code bank. A 32-bit mask bank sets which bits count. A mask bit of 1 makes its bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.

The code/mask bank can act as one 32-bit filter, as two 16-bit filters, or as four 8-bit filters. It can also be closed so that nothing passes. On acceptance the block pulses accept for one cycle and reports which filter won on a 2-bit hit index. When several filters match, the lowest-numbered one wins. It also sets a receive-full flag, which stays set until software clears it.

Identifier byte 0 is on bits 31:24 of the identifier bus and byte 3 is on bits 7:0. The code and mask buses use the same byte order. In an extended frame, byte 0 holds ID28..ID21 and byte 1 holds ID20..ID18, SRR, IDE and ID17..ID15. Byte 2 holds ID14..ID7 and byte 3 holds ID6..ID0 and RTR. In a standard frame, byte 0 holds ID10..ID3 and byte 1 holds ID2..ID0, RTR and IDE in its upper bits.

Top module: `can_id_filter`

## Requirements
- R1: With mode_i = 2'b00, a single filter compares all 32 identifier bits against code_i under mask_i. A hit reports index 0.
- R2: With mode_i = 2'b01, filter 0 compares code/mask bits 31:16 against identifier bits 31:16. Filter 1 compares code/mask bits 15:0 against identifier bits 31:16. Identifier bits 15:0 have no effect.
- R3: With mode_i = 2'b10, filter n (n = 0..3) compares code/mask byte n against identifier byte 0 (bits 31:24). Code/mask byte n is at bits 31-8n down to 24-8n. Identifier bytes 1..3 have no effect.
- R4: With mode_i = 2'b11, no frame is accepted and the receive-full flag is not set.
- R5: When more than one filter hits, hit_o reports the lowest-numbered hitting filter.
- R6: accept_o is high for exactly the one cycle after a clock edge at which frame_done_i was high and some filter hit. It is never high otherwise.
- R7: hit_o is updated only on acceptance. A rejected frame, or no frame, leaves it unchanged.
- R8: rxf_o is set on acceptance and then stays set until rxf_clr_i is sampled high. If an acceptance and a clear fall in the same cycle, the set wins.
- R9: After reset, accept_o, hit_o and rxf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_i | input | 32 | Received identifier bytes 0..3, byte 0 on bits 31:24 |
| code_i | input | 32 | Acceptance code bytes 0..3 |
| mask_i | input | 32 | Mask bytes 0..3, 1 = don't care |
| mode_i | input | 2 | 00 one filter, 01 two, 10 four, 11 closed |
| frame_done_i | input | 1 | Frame-complete strobe |
| rxf_clr_i | input | 1 | Software clear of receive-full |
| accept_o | output | 1 | One-cycle accept pulse |
| hit_o | output | 2 | Index of the winning filter |
| rxf_o | output | 1 | Receive-full flag |

## Verification
The decision is taken at the clock edge that samples the strobe, so accept_o, hit_o and rxf_o are due one edge later. The bench drives the strobe on a falling edge and reads all three outputs on the following falling edge. It reads accept_o again one cycle later to confirm that it has dropped. Rejections and strobe-free cycles are checked at those same sample points to show that hit_o and rxf_o have not moved. The clear is likewise checked one edge after it is applied.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_SLOT = 4;

  typedef enum logic [1:0] {
    FILT_ONE    = 2'b00,
    FILT_TWO    = 2'b01,
    FILT_FOUR   = 2'b10,
    FILT_CLOSED = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NS = NUM_SLOT,
  localparam int unsigned WW = BW * NS,
  localparam int unsigned HW = WW / 2
) (
  input  logic [WW-1:0] id_i,
  input  logic [WW-1:0] code_i,
  input  logic [WW-1:0] mask_i,
  input  logic [1:0]    mode_i,
  output logic [NS-1:0] hits_o
);
  logic          full_hit;
  logic [1:0]    half_hit;
  logic [NS-1:0] byte_hit;

  // mask bit 1 = don't care
  assign full_hit = &(~(id_i ^ code_i) | mask_i);

  for (genvar f = 0; f < 2; f++) begin : g_half
    localparam int unsigned TOP = WW - 1 - f * HW;
    assign half_hit[f] = &(~(id_i[WW-1 -: HW] ^ code_i[TOP -: HW]) | mask_i[TOP -: HW]);
  end

  for (genvar n = 0; n < NS; n++) begin : g_byte
    localparam int unsigned TOP = WW - 1 - n * BW;
    assign byte_hit[n] = &(~(id_i[WW-1 -: BW] ^ code_i[TOP -: BW]) | mask_i[TOP -: BW]);
  end

  always_comb begin
    hits_o = '0;
    unique case (filt_mode_e'(mode_i))
      FILT_ONE:    hits_o[0]   = full_hit;
      FILT_TWO:    hits_o[1:0] = half_hit;
      FILT_FOUR:   hits_o      = byte_hit;
      FILT_CLOSED: hits_o      = '0;
      default:     hits_o      = '0;
    endcase
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int unsigned NS = 4,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] hits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |hits_i;

  // lowest hit wins
  always_comb begin
    if (any_o) begin
      assert_lowest_R5: assert (hits_i[idx_o] &&
        ((hits_i & ((NS'(1) << idx_o) - NS'(1))) == '0));
    end
  end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NS = NUM_SLOT,
  localparam int unsigned WW = BW * NS,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] id_i,
  input  logic [WW-1:0] code_i,
  input  logic [WW-1:0] mask_i,
  input  logic [1:0]    mode_i,
  input  logic          frame_done_i,
  input  logic          rxf_clr_i,
  output logic          accept_o,
  output logic [IW-1:0] hit_o,
  output logic          rxf_o
);
  logic [NS-1:0] hits;
  logic          any_hit;
  logic [IW-1:0] win_idx;
  logic          take;

  can_filt_match #(.BW(BW), .NS(NS)) u_match (
    .id_i   (id_i),
    .code_i (code_i),
    .mask_i (mask_i),
    .mode_i (mode_i),
    .hits_o (hits)
  );

  can_filt_prio #(.NS(NS)) u_prio (
    .hits_i (hits),
    .any_o  (any_hit),
    .idx_o  (win_idx)
  );

  assign take = frame_done_i & any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      hit_o    <= '0;
      rxf_o    <= 1'b0;
    end else begin
      accept_o <= take;
      if (take) hit_o <= win_idx;
      if (take)           rxf_o <= 1'b1;
      else if (rxf_clr_i) rxf_o <= 1'b0;
    end
  end

  assert_accept_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(frame_done_i));

  assert_closed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ($past(mode_i) != 2'b11));

  assert_hit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> $stable(hit_o));

  assert_rxf_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> rxf_o);

  assert_rxf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rxf_o) && !$past(rxf_clr_i)) |-> rxf_o);
endmodule

// File: tb/can_id_filter_bench.sv
`timescale 1ns/1ps
module can_id_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] id_i = '0, code_i = '0, mask_i = '0;
  logic [1:0]  mode_i = 2'b00;
  logic        frame_done_i = 1'b0, rxf_clr_i = 1'b0;
  logic        accept_o, rxf_o;
  logic [1:0]  hit_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  can_id_filter u_can_id_filter (
    .clk_i, .rst_ni, .id_i, .code_i, .mask_i, .mode_i,
    .frame_done_i, .rxf_clr_i, .accept_o, .hit_o, .rxf_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe a frame, sample outputs one edge later
  task automatic frame(logic [31:0] id, logic [31:0] code, logic [31:0] mask,
                       logic [1:0] mode, logic clr);
    @(negedge clk_i);
    id_i = id; code_i = code; mask_i = mask; mode_i = mode;
    frame_done_i = 1'b1; rxf_clr_i = clr;
    @(negedge clk_i);
    frame_done_i = 1'b0; rxf_clr_i = 1'b0;
  endtask

  task automatic clear_rxf();
    @(negedge clk_i); rxf_clr_i = 1'b1;
    @(negedge clk_i); rxf_clr_i = 1'b0;
    check("R8 clear", rxf_o, 0);
  endtask

  task automatic t_reset();
    check("R9 accept", accept_o, 0);
    check("R9 hit", hit_o, 0);
    check("R9 rxf", rxf_o, 0);
  endtask

  task automatic t_single();
    frame(32'h1234_5678, 32'h1234_5678, 32'h0, 2'b00, 1'b0);
    check("R1 exact accept", accept_o, 1);
    check("R1 hit", hit_o, 0);
    check("R8 set", rxf_o, 1);
    @(negedge clk_i);
    check("R6 pulse drops", accept_o, 0);
    check("R8 held", rxf_o, 1);
    clear_rxf();
    frame(32'h1234_5679, 32'h1234_5678, 32'h0, 2'b00, 1'b0);
    check("R1 lsb mismatch", accept_o, 0);
    check("R8 no set", rxf_o, 0);
    frame(32'h1234_5679, 32'h1234_5678, 32'h1, 2'b00, 1'b0);
    check("R1 masked accept", accept_o, 1);
    clear_rxf();
  endtask

  task automatic t_dual();
    frame(32'hABCD_FFFF, 32'h0000_ABCD, 32'h0, 2'b01, 1'b0);
    check("R2 filter1 accept", accept_o, 1);
    check("R2 filter1 hit", hit_o, 1);
    frame(32'h1111_ABCD, 32'h0000_ABCD, 32'h0, 2'b01, 1'b0);
    check("R2 low id ignored reject", accept_o, 0);
    check("R7 hit held", hit_o, 1);
    frame(32'hABCD_0000, 32'hABCD_ABCD, 32'h0, 2'b01, 1'b0);
    check("R5 both hit", hit_o, 0);
    clear_rxf();
  endtask

  task automatic t_quad();
    frame(32'hA5FF_FFFF, 32'h0011_A5A5, 32'h0, 2'b10, 1'b0);
    check("R3 accept", accept_o, 1);
    check("R5 quad lowest", hit_o, 2);
    frame(32'h7E00_0000, 32'h0011_2233, 32'h0000_00FF, 2'b10, 1'b0);
    check("R3 byte3 masked", hit_o, 3);
    frame(32'h7E00_0000, 32'h0011_2233, 32'h0, 2'b10, 1'b0);
    check("R3 no byte match", accept_o, 0);
    clear_rxf();
  endtask

  task automatic t_closed();
    frame(32'h0, 32'h0, 32'hFFFF_FFFF, 2'b11, 1'b0);
    check("R4 no accept", accept_o, 0);
    check("R4 no rxf", rxf_o, 0);
    check("R7 hit unchanged", hit_o, 3);
  endtask

  task automatic t_no_strobe();
    @(negedge clk_i);
    id_i = 32'h0; code_i = 32'h0; mask_i = 32'h0; mode_i = 2'b00;
    @(negedge clk_i);
    check("R6 no strobe", accept_o, 0);
    check("R7 no strobe hit", hit_o, 3);
  endtask

  task automatic t_set_wins();
    frame(32'h0, 32'h0, 32'h0, 2'b00, 1'b0);
    frame(32'h0, 32'h0, 32'h0, 2'b00, 1'b1);
    check("R8 set beats clear", rxf_o, 1);
    check("R1 hit zero", hit_o, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_single();
    t_dual();
    t_quad();
    t_closed();
    t_no_strobe();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule